// File: doc/BRIEF.md
# Fractional Timer Tick Prescaler

This block produces the advance pulses for a free-running 64-bit timebase counter. One of two input clock-enable streams feeds it: a crystal-derived stream or an alternate stream. Each input pulse adds a 32-bit ratio word into a phase accumulator. A tick is produced whenever the accumulated phase reaches one whole unit, which is 2^31. Any amount past the unit stays in the accumulator. The tick rate is therefore the selected input rate times ratio / 2^31. Each tick advances the counter by one or by two.

Software sets the block up through a small register port. A control word holds the source select in bit 8 and the step select in bit 9. A ratio word holds the 32-bit fraction. The counter is read back as two 32-bit words on the same port. Clock-domain crossing between the two sources is done outside the block: each source arrives here as a one-cycle enable in the block's clock domain.

Top module: `frac_tick_prescaler`

## Requirements
- R1: After reset the counter is 0 and `tick_o` is low. The control word reads 0, which selects the crystal source and a step of 1. The ratio word reads 0x80000000.
- R2: Control bit 8 selects the input stream: 0 selects `xtal_en` and 1 selects `alt_en`. The stream that is not selected has no effect on the counter.
- R3: Control bit 9 sets the step: 0 adds 1 to the counter on each tick and 1 adds 2.
- R4: With a ratio of 0x80000000, every cycle in which the selected enable is high produces exactly one tick.
- R5: On each selected-enable cycle the ratio is added to the accumulator. A tick occurs when the sum is 2^31 or more, and the sum minus 2^31 is kept. Starting from a cleared accumulator, N enabled cycles at ratio P give floor(N*P/2^31) ticks.
- R6: A ratio above 0x80000000 behaves exactly like 0x80000000: one tick per enabled cycle.
- R7: A write to the ratio word clears the accumulator, and no tick occurs in the write cycle. A write to the control word takes effect from the next cycle.
- R8: The register address map is: 0 is control, 1 is ratio, 2 is counter bits 31:0, and 3 is counter bits 63:32. Only control bits 8 and 9 are stored, and all other control bits read as 0. Writes to addresses 2 and 3 have no effect.
- R9: `tick_o` is high in exactly those cycles that directly follow a counter advance. In every other cycle the counter holds its value.
- R10: A ratio of 0 never produces a tick, whatever the enables do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en | input | 1 | Crystal-derived input pulse, one cycle wide |
| alt_en | input | 1 | Alternate-source input pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| count_o | output | 64 | Timebase counter value |
| tick_o | output | 1 | Pulse marking a counter advance in the previous edge |

## Verification
The bench targets the following corner cases and the wrong behaviour each one would expose:
- A ratio just above one unit: a design that does not clamp it would let the accumulator wrap and skip ticks.
- A ratio write in the middle of accumulation: a design that keeps the old phase would tick one input early.
- The unselected source toggling on its own: a mux error would show up as counter motion.
- A ratio of 0, and the step-of-two mode with the source switched in the same control write.

Long random runs then compare every cycle's tick and counter value against a model built from the stated arithmetic. Any lost or duplicated remainder becomes visible as drift in those runs.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  // Register address map; the counter words follow RATIO_IDX in order.
  localparam int CTRL_IDX  = 0;
  localparam int RATIO_IDX = 1;
  localparam int CNT_BASE  = 2;

  // Stored control fields
  typedef struct packed {
    logic step_two;
    logic src_alt;
  } tfp_ctrl_t;
endpackage

// File: rtl/tfp_regs.sv
module tfp_regs
  import tfp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int SRC_BIT   = 8,
  parameter int STEP_BIT  = 9,
  parameter logic [DATA_W-1:0] RATIO_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output tfp_ctrl_t         ctrl_q,
  output logic [DATA_W-1:0] ratio_q,
  output logic              ratio_wr
);
  logic ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));
  assign ratio_wr = wr_en && (wr_addr == ADDR_W'(RATIO_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.src_alt  <= wr_data[SRC_BIT];
      ctrl_q.step_two <= wr_data[STEP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_RST;
    end else if (ratio_wr) begin
      ratio_q <= wr_data;
    end
  end
endmodule

// File: rtl/tfp_phase_acc.sv
module tfp_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [ACC_W-1:0] ratio,
  output logic [ACC_W-1:0] eff_ratio,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry
);
  localparam logic [ACC_W-1:0] UNITY = {1'b1, {(ACC_W-1){1'b0}}};

  // Limit the ratio to one whole unit per input pulse.
  function automatic logic [ACC_W-1:0] clamp_ratio(input logic [ACC_W-1:0] r);
    return (r > UNITY) ? UNITY : r;
  endfunction

  // Widened sum, so that the carry out of the top bit is kept
  function automatic logic [ACC_W:0] phase_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W:0]   sum;
  logic             whole;
  logic [ACC_W-1:0] acc_d;

  assign eff_ratio = clamp_ratio(ratio);
  assign sum       = phase_sum(acc_q, eff_ratio);
  assign whole     = (sum >= {1'b0, UNITY});
  assign carry     = adv && !clear && whole;

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (adv) begin
      acc_d = whole ? ACC_W'(sum - {1'b0, UNITY}) : sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/tfp_counter.sv
module tfp_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             step_two,
  output logic [CNT_W-1:0] count_q,
  output logic             tick_q
);
  function automatic logic [CNT_W-1:0] step_amount(input logic two);
    return two ? CNT_W'(2) : CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= adv;
      if (adv) count_q <= count_q + step_amount(step_two);
    end
  end
endmodule

// File: rtl/frac_tick_prescaler.sv
module frac_tick_prescaler
  import tfp_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int SRC_BIT  = 8,
  parameter int STEP_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic              alt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              tick_o
);
  localparam int NWORDS = CNT_W / DATA_W;
  localparam logic [DATA_W-1:0] UNITY = {1'b1, {(DATA_W-1){1'b0}}};

  tfp_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] ratio_q;
  logic              ratio_wr;
  logic              sel_en;
  logic [DATA_W-1:0] eff_ratio;
  logic [DATA_W-1:0] acc_q;
  logic              tick_event;
  logic              step_two;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] cnt_word [NWORDS];

  tfp_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_BIT(SRC_BIT),
    .STEP_BIT(STEP_BIT), .RATIO_RST(UNITY)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .ratio_q(ratio_q), .ratio_wr(ratio_wr)
  );

  assign sel_en   = ctrl_q.src_alt ? alt_en : xtal_en;
  assign step_two = ctrl_q.step_two;

  tfp_phase_acc #(.ACC_W(DATA_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .clear(ratio_wr), .adv(sel_en),
    .ratio(ratio_q), .eff_ratio(eff_ratio), .acc_q(acc_q), .carry(tick_event)
  );

  tfp_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .adv(tick_event), .step_two(step_two),
    .count_q(count_o), .tick_q(tick_o)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign cnt_word[w] = count_o[w*DATA_W +: DATA_W];
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[SRC_BIT]  = ctrl_q.src_alt;
    ctrl_word[STEP_BIT] = ctrl_q.step_two;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_IDX)) begin
      rd_data = ctrl_word;
    end else if (rd_addr == ADDR_W'(RATIO_IDX)) begin
      rd_data = ratio_q;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (rd_addr == ADDR_W'(CNT_BASE + w)) rd_data = cnt_word[w];
      end
    end
  end
endmodule

// File: rtl/frac_tick_prescaler_chk.sv
module frac_tick_prescaler_chk #(
  parameter int ACC_W = 32,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_en,
  input logic             ratio_wr,
  input logic [ACC_W-1:0] eff_ratio,
  input logic [ACC_W-1:0] acc_q,
  input logic             step_two,
  input logic [CNT_W-1:0] count,
  input logic             tick
);
  localparam logic [ACC_W-1:0] UNITY = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);

  AST_ACC_BELOW_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < UNITY); // R5
  AST_RATIO_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    eff_ratio <= UNITY); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (count == $past(count) + ($past(step_two) ? TWO : ONE))); // R3
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> $stable(count)); // R9
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(sel_en) && !$past(ratio_wr))); // R2
  AST_UNITY_EVERY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && !ratio_wr && eff_ratio == UNITY) |=> tick); // R4
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> (acc_q == '0)); // R7
endmodule

bind frac_tick_prescaler frac_tick_prescaler_chk #(
  .ACC_W(DATA_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .ratio_wr(ratio_wr),
  .eff_ratio(eff_ratio), .acc_q(acc_q), .step_two(step_two),
  .count(count_o), .tick(tick_o)
);

// File: tb/test_frac_tick_prescaler.sv
module test_frac_tick_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] UNIT = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_en = 1'b0, alt_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] count_o;
  logic        tick_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_ctrl, m_ratio, m_acc;
  logic [63:0] m_cnt;
  logic        m_tick;

  frac_tick_prescaler i_frac_tick_prescaler (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .alt_en(alt_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count_o(count_o), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] lim(input logic [31:0] r);
    return (r > UNIT) ? UNIT : r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, {32'h0, rd_data}, {32'h0, exp});
  endtask

  // One clock: drive, advance the model, check tick and count after the edge.
  task automatic cyc(input bit we, input logic [1:0] wa, input logic [31:0] wd,
                     input bit xe, input bit ae, input string tag);
    logic [32:0] s;
    bit en;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; xtal_en = xe; alt_en = ae;
    m_tick = 1'b0;
    en = m_ctrl[8] ? ae : xe;
    if (we && wa == 2'd1) begin
      m_ratio = wd;
      m_acc = '0;
    end else if (en) begin
      s = {1'b0, m_acc} + {1'b0, lim(m_ratio)};
      if (s >= {1'b0, UNIT}) begin
        m_tick = 1'b1;
        m_acc = 32'(s - {1'b0, UNIT});
        m_cnt = m_cnt + (m_ctrl[9] ? 64'd2 : 64'd1);
      end else begin
        m_acc = s[31:0];
      end
    end
    if (we && wa == 2'd0) m_ctrl = wd & 32'h0000_0300;
    @(posedge clk);
    #1;
    chk({tag, " tick R9"}, {63'h0, tick_o}, {63'h0, m_tick});
    chk({tag, " count"}, count_o, m_cnt);
  endtask

  task automatic idle(input int n, input bit xe, input bit ae, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 32'h0, xe, ae, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] base;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    m_ctrl = 0; m_ratio = UNIT; m_acc = 0; m_cnt = 0; m_tick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", count_o, 64'd0);
    chk("R1 tick", {63'h0, tick_o}, 64'd0);
    rd_chk(2'd0, 32'h0, "R1 ctrl");
    rd_chk(2'd1, UNIT, "R1 ratio");
    rd_chk(2'd3, 32'h0, "R1 count high");

    // R4 unity ratio: one tick per enable
    idle(10, 1, 0, "R4");
    chk("R4 ten ticks", count_o, 64'd10);

    // R2 source select
    idle(5, 0, 1, "R2 alt ignored");
    chk("R2 alt ignored", count_o, 64'd10);
    cyc(1, 2'd0, 32'h0000_0100, 0, 0, "R2 ctrl");
    idle(4, 1, 0, "R2 xtal ignored");
    chk("R2 xtal ignored", count_o, 64'd10);
    idle(3, 0, 1, "R2 alt");
    chk("R2 alt counts", count_o, 64'd13);

    // R3 step of two
    cyc(1, 2'd0, 32'h0000_0300, 0, 0, "R3 ctrl");
    idle(4, 0, 1, "R3");
    chk("R3 step two", count_o, 64'd21);

    // R8 control storage and read map
    cyc(1, 2'd0, 32'hFFFF_FFFF, 0, 0, "R8 ctrl");
    rd_chk(2'd0, 32'h0000_0300, "R8 ctrl bits");
    cyc(1, 2'd0, 32'h0, 0, 0, "R8 ctrl clr");
    cyc(1, 2'd2, 32'h0000_FFFF, 1, 0, "R8 ro write");
    rd_chk(2'd2, 32'd22, "R8 count low read-only");
    rd_chk(2'd3, 32'd0, "R8 count high");

    // R5 half ratio
    cyc(1, 2'd1, 32'h4000_0000, 0, 0, "R5 ratio");
    rd_chk(2'd1, 32'h4000_0000, "R8 ratio read");
    base = count_o;
    idle(8, 1, 0, "R5");
    chk("R5 half rate", count_o, base + 64'd4);
    cyc(1, 2'd1, 32'h1555_5555, 0, 0, "R5 ratio third");
    base = count_o;
    idle(30, 1, 0, "R5 third");
    chk("R5 floor", count_o, base + ((64'd30 * 64'h1555_5555) >> 31));

    // R10 zero ratio
    cyc(1, 2'd1, 32'h0, 0, 0, "R10 ratio");
    base = count_o;
    idle(20, 1, 1, "R10");
    chk("R10 no ticks", count_o, base);

    // R6 clamp
    cyc(1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R6 ratio");
    base = count_o;
    idle(6, 1, 0, "R6");
    chk("R6 clamp max", count_o, base + 64'd6);
    cyc(1, 2'd1, 32'h8000_0001, 0, 0, "R6 ratio");
    base = count_o;
    idle(5, 1, 0, "R6 just above");
    chk("R6 clamp above unit", count_o, base + 64'd5);

    // R7 ratio write clears phase
    cyc(1, 2'd1, 32'h6000_0000, 0, 0, "R7 ratio");
    base = count_o;
    idle(1, 1, 0, "R7");
    cyc(1, 2'd1, 32'h6000_0000, 1, 0, "R7 rewrite");
    idle(1, 1, 0, "R7 after clear");
    chk("R7 cleared phase", count_o, base);
    idle(1, 1, 0, "R7 second");
    chk("R7 tick after two", count_o, base + 64'd1);

    // Random mix checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [1:0] wa;
      logic [31:0] wd;
      we = ($urandom % 16) == 0;
      wa = 2'($urandom % 4);
      case ($urandom % 6)
        0: wd = 32'h0;
        1: wd = UNIT;
        2: wd = 32'hFFFF_FFFF;
        3: wd = 32'h0000_0300;
        4: wd = 32'h0000_0100;
        default: wd = $urandom;
      endcase
      cyc(we, wa, wd, 1'($urandom), 1'($urandom), "R5 random");
    end
    rd_chk(2'd2, m_cnt[31:0], "R8 final low");
    rd_chk(2'd0, m_ctrl, "R8 final ctrl");
    summary();
  end
endmodule